// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact stored-program processor. Program and data share one word-addressed memory, and results pass through a single accumulator. Each 16-bit instruction word holds an opcode and an absolute address. The core steps every instruction through a fixed sequence of states:

- fetch the instruction word;
- latch and decode it;
- read the memory operand into a holding register, for instructions that use one;
- execute.

It has load, store, add, subtract, port input and output, a signed compare, an unconditional jump, a conditional jump on a negative accumulator, three jumps on the compare flags, and halt.

The core drives the address of a synchronous memory. Read data comes back one clock after the address is presented. A write happens on the clock edge at which the write enable is high. A program reads a value from the input port and presents results on a registered output port. A one-cycle strobe marks each new output value. After a halt the core stops all fetching, and only reset restarts it.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, the PC, accumulator, compare flags and output register are held at zero. Halted and outStrobe are low, and memAddr shows address 0. The first instruction after reset is fetched from address 0, and no compare jump is taken before a compare has executed.
- R2: An instruction word carries its opcode in bits [15:12] and its operand address in bits [11:0]. The opcodes are:
  - 0 no-op, 1 load, 2 store, 3 add, 4 subtract;
  - 5 input, 6 output, 7 jump, 8 jump-if-negative, 9 halt;
  - A compare, B jump-if-greater, C jump-if-equal, D jump-if-less.
- R3: Load sets the accumulator to mem[operand]. Add sets it to accumulator + mem[operand], and subtract sets it to accumulator − mem[operand]. Both wrap modulo 2^16.
- R4: Store writes the accumulator to mem[operand], with memWe high for exactly one cycle.
- R5: Input copies inData into the accumulator. Output copies the accumulator into outData, which holds its value, and raises outStrobe for exactly one cycle.
- R6: Compare treats the accumulator and mem[operand] as signed values. It sets exactly one of the greater, equal and less flags and leaves the accumulator unchanged.
- R7: Jump-if-greater, jump-if-equal and jump-if-less load the PC with the operand when their flag is set. Otherwise execution continues at the next word.
- R8: Jump always loads the PC with the operand. Jump-if-negative does so only when accumulator bit 15 is 1.
- R9: Halt raises halted. Halted then stays high, and no further memory write or output strobe occurs until reset.
- R10: The no-op and the spare opcodes E and F change no architectural state and continue at the next word.
- R11: Instructions with a memory read operand (load, add, subtract, compare) take 5 clocks. All other instructions take 3 clocks, and halted rises at the end of a halt's third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory word address |
| memWdata | output | 16 | Memory write data (the accumulator) |
| memRdata | input | 16 | Memory read data, valid one clock after its address |
| memWe | output | 1 | Memory write enable |
| inData | input | 16 | Input port value |
| outData | output | 16 | Registered output port value |
| outStrobe | output | 1 | One-cycle pulse on each new output value |
| halted | output | 1 | High once a halt has executed |

## Verification
Every result is due at a fixed clock count after reset release. A 3-clock instruction's effect is visible after its third edge, and a 5-clock instruction's after its fifth. The bench therefore releases reset on a falling edge and counts rising edges. It samples every output and counter on the following falling edge, never at the active edge. Program results are checked once halted is seen. The exact number of edges until halted is itself checked against the per-instruction cycle counts. The one-cycle width of the store and strobe pulses is checked by counting them over a whole program run.

// File: rtl/accpu_pkg.sv
package accpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0, OP_LDA = 4'h1, OP_STA = 4'h2, OP_ADD = 4'h3,
    OP_SUB  = 4'h4, OP_IN  = 4'h5, OP_OUT = 4'h6, OP_JMP = 4'h7,
    OP_JN   = 4'h8, OP_HLT = 4'h9, OP_CMP = 4'hA, OP_JG  = 4'hB,
    OP_JE   = 4'hC, OP_JL  = 4'hD, OP_SP0 = 4'hE, OP_SP1 = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ACC_KEEP, ACC_FROM_B, ACC_SUM, ACC_DIFF, ACC_FROM_IN
  } accSel_e;

  typedef struct packed {
    logic    loadIr;
    logic    incPc;
    logic    jumpPc;
    logic    loadB;
    accSel_e accSel;
    logic    setFlags;
    logic    memWrite;
    logic    addrOperand;
    logic    loadOut;
  } ctrl_t;

endpackage

// File: rtl/accpu_ctrl.sv
module accpu_ctrl
  import accpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opcode,
  input  logic    flagGt,
  input  logic    flagEq,
  input  logic    flagLt,
  input  logic    accNeg,
  output ctrl_t   ctrl,
  output logic    halted
);

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPER, S_LOADB, S_EXEC, S_HALT
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      S_FETCH:  stateNext = S_DECODE;
      S_DECODE: begin
        ctrl.loadIr = 1'b1;
        ctrl.incPc  = 1'b1;
        stateNext   = S_OPER;
      end
      S_OPER: begin
        ctrl.addrOperand = 1'b1;
        stateNext        = S_FETCH;
        case (opcode)
          OP_LDA, OP_ADD, OP_SUB, OP_CMP: stateNext = S_LOADB;
          OP_STA: ctrl.memWrite = 1'b1;
          OP_IN:  ctrl.accSel   = ACC_FROM_IN;
          OP_OUT: ctrl.loadOut  = 1'b1;
          OP_JMP: ctrl.jumpPc   = 1'b1;
          OP_JN:  ctrl.jumpPc   = accNeg;
          OP_JG:  ctrl.jumpPc   = flagGt;
          OP_JE:  ctrl.jumpPc   = flagEq;
          OP_JL:  ctrl.jumpPc   = flagLt;
          OP_HLT: stateNext     = S_HALT;
          default: ;
        endcase
      end
      S_LOADB: begin
        ctrl.loadB = 1'b1;
        stateNext  = S_EXEC;
      end
      S_EXEC: begin
        stateNext = S_FETCH;
        case (opcode)
          OP_LDA:  ctrl.accSel   = ACC_FROM_B;
          OP_ADD:  ctrl.accSel   = ACC_SUM;
          OP_SUB:  ctrl.accSel   = ACC_DIFF;
          OP_CMP:  ctrl.setFlags = 1'b1;
          default: ;
        endcase
      end
      S_HALT:   stateNext = S_HALT;
      default:  stateNext = S_FETCH;
    endcase
  end

  assign halted = (state == S_HALT);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ctrl.memWrite && !ctrl.loadOut && !ctrl.loadIr);

  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |=> !ctrl.memWrite);

endmodule

// File: rtl/accpu_datapath.sv
module accpu_datapath
  import accpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output opcode_e           opcode,
  output logic              flagGt,
  output logic              flagEq,
  output logic              flagLt,
  output logic              accNeg
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, acc, bReg, outReg;
  logic [ADDR_W-1:0] irOperand;
  logic              outStb;

  assign irOperand = ir[ADDR_W-1:0];
  assign opcode    = opcode_e'(ir[DATA_W-1 -: OP_W]);
  assign accNeg    = acc[DATA_W-1];
  assign memAddr   = ctrl.addrOperand ? irOperand : pc;
  assign memWdata  = acc;
  assign outData   = outReg;
  assign outStrobe = outStb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      acc    <= '0;
      bReg   <= '0;
      outReg <= '0;
      outStb <= 1'b0;
      {flagGt, flagEq, flagLt} <= 3'b000;
    end else begin
      if (ctrl.loadIr) ir <= memRdata;
      if (ctrl.incPc)       pc <= pc + PC_STEP;
      else if (ctrl.jumpPc) pc <= irOperand;
      if (ctrl.loadB) bReg <= memRdata;
      case (ctrl.accSel)
        ACC_FROM_B:  acc <= bReg;
        ACC_SUM:     acc <= acc + bReg;
        ACC_DIFF:    acc <= acc - bReg;
        ACC_FROM_IN: acc <= inData;
        default:     ;
      endcase
      if (ctrl.setFlags) begin
        flagGt <= $signed(acc) >  $signed(bReg);
        flagEq <= acc == bReg;
        flagLt <= $signed(acc) <  $signed(bReg);
      end
      outStb <= ctrl.loadOut;
      if (ctrl.loadOut) outReg <= acc;
    end
  end

  // R6
  flags_onehot0_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flagGt, flagEq, flagLt}));

  // R6
  flags_set_one_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.setFlags |=> $onehot({flagGt, flagEq, flagLt}));

  // R6
  cmp_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.setFlags |=> $stable(acc));

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.incPc || ctrl.jumpPc) |=> $stable(pc));

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> !outStrobe);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import accpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output logic              halted
);

  ctrl_t   ctrlBus;
  opcode_e opcode;
  logic    flagGt, flagEq, flagLt, accNeg;

  accpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .flagGt(flagGt), .flagEq(flagEq), .flagLt(flagLt), .accNeg(accNeg),
    .ctrl(ctrlBus), .halted(halted)
  );

  accpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .memRdata(memRdata),
    .inData(inData), .memAddr(memAddr), .memWdata(memWdata),
    .outData(outData), .outStrobe(outStrobe), .opcode(opcode),
    .flagGt(flagGt), .flagEq(flagEq), .flagLt(flagLt), .accNeg(accNeg)
  );

  assign memWe = ctrlBus.memWrite;

endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  import accpu_pkg::*;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MEMN = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata, inData, outData;
  logic          memWe, outStrobe, halted;

  acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .inData(inData),
    .outData(outData), .outStrobe(outStrobe), .halted(halted)
  );

  logic [DW-1:0] mem [MEMN];
  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    memRdata <= mem[memAddr[7:0]];
  end

  int errors = 0;
  int checks = 0;
  int strobeCnt = 0;
  int haltWrites = 0;
  int cycleCnt = 0;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (rst) begin
      strobeCnt  <= 0;
      haltWrites <= 0;
    end else begin
      if (outStrobe) strobeCnt <= strobeCnt + 1;
      if (halted && memWe) haltWrites <= haltWrites + 1;
    end
  end

  always @(posedge clk) begin
    if (cycleCnt == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  jop;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_ADD, OP_JMP, 16'h0003, 16'h0004, 16'h0007},
    '{OP_ADD, OP_JMP, 16'hFFFF, 16'h0002, 16'h0001},
    '{OP_SUB, OP_JMP, 16'h0005, 16'h0007, 16'hFFFE},
    '{OP_LDA, OP_JMP, 16'h1234, 16'hABCD, 16'hABCD},
    '{OP_CMP, OP_JG,  16'h0005, 16'h0003, 16'h0005},
    '{OP_CMP, OP_JG,  16'hFFFF, 16'h0001, 16'h5555},
    '{OP_CMP, OP_JL,  16'hFFFF, 16'h0001, 16'hFFFF},
    '{OP_CMP, OP_JE,  16'h0042, 16'h0042, 16'h0042},
    '{OP_CMP, OP_JE,  16'h0042, 16'h0043, 16'h5555},
    '{OP_CMP, OP_JL,  16'h7FFF, 16'h8000, 16'h5555},
    '{OP_SUB, OP_JN,  16'h0001, 16'h0002, 16'hFFFF},
    '{OP_ADD, OP_JN,  16'h0001, 16'h0002, 16'h5555},
    '{OP_NOP, OP_JMP, 16'h0777, 16'h0001, 16'h0777},
    '{OP_SP0, OP_JMP, 16'h0777, 16'h0001, 16'h0777}
  };

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] arg);
    return {op, arg};
  endfunction

  function automatic string tagOf(input logic [3:0] op, input logic [3:0] jop);
    if (op == OP_CMP) return "R6 R7";
    if (jop == OP_JN) return "R8";
    if (op == OP_NOP || op == OP_SP0) return "R10";
    if (op == OP_LDA) return "R2 R3";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MEMN; i++) mem[i] = 16'h0000;
  endtask

  task automatic runToHalt(output int n);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    inData = 16'h0000;

    // Vector table: load A, apply op with B, optional jump to OUT, else load 0x5555
    for (int v = 0; v < NV; v++) begin
      holdReset();
      mem[0] = ins(OP_LDA, 12'h080);
      mem[1] = ins(VECS[v].op, 12'h081);
      mem[2] = ins(VECS[v].jop, 12'h005);
      mem[3] = ins(OP_LDA, 12'h082);
      mem[4] = ins(OP_NOP, 12'h000);
      mem[5] = ins(OP_OUT, 12'h000);
      mem[6] = ins(OP_HLT, 12'h000);
      mem[8'h80] = VECS[v].a;
      mem[8'h81] = VECS[v].b;
      mem[8'h82] = 16'h5555;
      runToHalt(n);
      check({tagOf(VECS[v].op, VECS[v].jop), " vector result"}, outData, VECS[v].exp);
      check("R5 one strobe per OUT", strobeCnt, 1);
    end

    // Input, store, add back, output; 3+3+5+3+3 clocks
    holdReset();
    inData = 16'h0123;
    mem[0] = ins(OP_IN, 12'h000);
    mem[1] = ins(OP_STA, 12'h090);
    mem[2] = ins(OP_ADD, 12'h090);
    mem[3] = ins(OP_OUT, 12'h000);
    mem[4] = ins(OP_HLT, 12'h000);
    runToHalt(n);
    check("R4 stored word", mem[8'h90], 16'h0123);
    check("R5 IN then doubled output", outData, 16'h0246);
    check("R11 cycles for IN/STA/ADD/OUT/HLT", n, 17);

    // Reset state, sampled while reset is held
    holdReset();
    check("R1 memAddr in reset", memAddr, 0);
    check("R1 outData cleared", outData, 0);
    check("R1 halted low", halted, 0);
    check("R1 outStrobe low", outStrobe, 0);
    check("R1 memWe low", memWe, 0);

    // Timing: two no-ops then halt
    mem[0] = ins(OP_NOP, 12'h000);
    mem[1] = ins(OP_SP1, 12'h000);
    mem[2] = ins(OP_HLT, 12'h000);
    runToHalt(n);
    check("R11 cycles NOP,NOP,HLT", n, 9);

    holdReset();
    mem[0] = ins(OP_LDA, 12'h010);
    mem[1] = ins(OP_HLT, 12'h000);
    runToHalt(n);
    check("R11 cycles LDA,HLT", n, 8);

    // Halt stops everything
    holdReset();
    mem[0] = ins(OP_HLT, 12'h000);
    mem[1] = ins(OP_STA, 12'h091);
    mem[2] = ins(OP_OUT, 12'h000);
    mem[8'h91] = 16'hBEEF;
    runToHalt(n);
    repeat (20) @(negedge clk);
    check("R9 halted stays high", halted, 1);
    check("R9 no write after halt", haltWrites, 0);
    check("R9 word after HLT not executed", mem[8'h91], 16'hBEEF);
    check("R9 no strobe after halt", strobeCnt, 0);

    // Set equal flag, then reset: flags and ACC must be cleared
    holdReset();
    mem[0] = ins(OP_LDA, 12'h080);
    mem[1] = ins(OP_CMP, 12'h080);
    mem[2] = ins(OP_HLT, 12'h000);
    mem[8'h80] = 16'h0099;
    runToHalt(n);
    holdReset();
    mem[0] = ins(OP_JE, 12'h004);
    mem[1] = ins(OP_JG, 12'h004);
    mem[2] = ins(OP_JL, 12'h004);
    mem[3] = ins(OP_OUT, 12'h000);
    mem[4] = ins(OP_HLT, 12'h000);
    runToHalt(n);
    check("R1 flags cleared, no jump taken", strobeCnt, 1);
    check("R1 ACC cleared", outData, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule